// File: doc/BRIEF.md
# Joystick Axis Key-Press Duty Modulator

This block turns one sampled joystick axis into a stream of keyboard make and break bytes, so that the stick's deflection becomes the share of a fixed period during which a direction key is held. The axis sample is an unsigned 8-bit value with a valid strobe. Its top bit picks one of two direction keys. Three further bits give a magnitude from 0 to 7, and that magnitude is the number of held slots in a seven-slot period.

While the key is held, the make code is sent at the start of every held slot. When the held part ends, a release prefix and then the key code go out. The rest of the period is silent. Bytes leave as a registered byte with a one-cycle request strobe towards a downstream serializer. The strobe only fires when the serializer's ready input is high. A new sample is taken only at a period boundary. One instance serves one axis; a second instance with the other key pair serves the other axis.

Top module: `axis_key_pwm`

## Requirements
- R1: While reset is held and right after it, `smp_ready` is 1 and `tx_req` is 0.
- R2: When sample bit 7 is 1 the key byte is `POS_KEY` (default 0x75, keypad 8); when bit 7 is 0 it is `NEG_KEY` (default 0x72, keypad 2).
- R3: The magnitude M is sample bits 6:4 when bit 7 is 1, and the inverse of bits 6:4 when bit 7 is 0. A period with M > 0 sends exactly M + 2 bytes.
- R4: When M is 0, no byte is sent during the period, and `smp_ready` returns after the full 7 slots.
- R5: For slot s = 0 .. M-1, a make byte (the key code) is issued at tick s·SLOT_TICKS after acceptance.
- R6: At tick M·SLOT_TICKS the release prefix 0xF0 is issued, and at tick M·SLOT_TICKS + GAP_TICKS the key code follows it.
- R7: A sample is accepted on a clock edge where `smp_valid` and `smp_ready` are both 1. `smp_ready` then stays 0 until the period ends, and `smp_valid` has no effect while it is 0. The period lasts 7·SLOT_TICKS ticks, or 7·SLOT_TICKS + 2·GAP_TICKS ticks when M is 7.
- R8: `tx_req` is high for single cycles only, only after an edge where `tx_ready` was 1. `tx_byte` holds still while a byte waits for ready. A byte that is due while ready is low goes out on the first edge on which ready is 1.
- R9: One tick is CLK_KHZ·TICK_US/1000 clock cycles, counted from the acceptance edge. An event due at tick n raises `tx_req` on the edge 2 cycles after the edge n ticks past acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Axis sample valid |
| smp_data | input | 8 | Unsigned axis sample (high byte of conversion) |
| smp_ready | output | 1 | Block is at a period boundary and takes a sample |
| tx_ready | input | 1 | Downstream serializer can take a byte |
| tx_req | output | 1 | One-cycle byte request strobe |
| tx_byte | output | 8 | Byte to be serialized |

## Verification
On every cycle, the assertions check the shape of the output handshake: a request follows a ready edge, requests are single cycles, the byte is held while it waits, the latched key and magnitude stay frozen across a busy period, a zero magnitude stays silent, and ticks never come back to back. The following can only be shown by the bench's reference model, which compares every cycle against the schedule it derives from each accepted sample: the exact cycle of each make, prefix and release byte, the key selected for each direction, the byte count per period, and the moment ready returns. This includes a stalled ready, back-to-back samples and valid pulses during a busy period.

// File: rtl/akp_pkg.sv
package akp_pkg;
   localparam logic [7:0] KC_KP8     = 8'h75;
   localparam logic [7:0] KC_KP2     = 8'h72;
   localparam logic [7:0] KC_KP4     = 8'h6B;
   localparam logic [7:0] KC_KP6     = 8'h74;
   localparam logic [7:0] KC_RELEASE = 8'hF0;

   localparam int MAG_W     = 3;
   localparam int SLOTS_PER = (1 << MAG_W) - 1;

   typedef logic [MAG_W-1:0] mag_t;
   typedef enum logic [1:0] {EV_MAKE, EV_PREFIX, EV_BREAK} ev_kind_t;
endpackage

// File: rtl/akp_tick_gen.sv
module akp_tick_gen #(
   parameter int TICK_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int DIV_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

   generate
      if (TICK_CYC < 1) begin : g_bad
         $error("TICK_CYC must be at least 1");
      end
      if (TICK_CYC == 1) begin : g_unit
         assign tick = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr)
               div_q <= '0;
            else if (div_q == DIV_W'(TICK_CYC - 1))
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_W'(TICK_CYC - 1));

         // R9
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/akp_axis_decode.sv
module akp_axis_decode
   import akp_pkg::*;
#(
   parameter int         SMP_W    = 8,
   parameter bit         FOLD_NEG = 1'b1,
   parameter logic [7:0] POS_KEY  = KC_KP8,
   parameter logic [7:0] NEG_KEY  = KC_KP2
) (
   input  logic [SMP_W-1:0] smp,
   output logic [7:0]       key,
   output mag_t             mag
);
   localparam int TOP = SMP_W - 1;
   localparam int MHI = SMP_W - 2;

   logic [SMP_W-1:0] folded;

   generate
      if (SMP_W < MAG_W + 1) begin : g_bad
         $error("SMP_W too narrow for a sign bit plus magnitude");
      end
      if (FOLD_NEG) begin : g_fold
         assign folded = smp[TOP] ? smp : ~smp;
      end else begin : g_raw
         assign folded = smp;
      end
   endgenerate

   assign key = smp[TOP] ? POS_KEY : NEG_KEY;
   assign mag = folded[MHI -: MAG_W];
endmodule

// File: rtl/akp_event_sched.sv
module akp_event_sched
   import akp_pkg::*;
#(
   parameter int         SLOT_TICKS = 32,
   parameter int         GAP_TICKS  = 4,
   parameter logic [7:0] BRK_CODE   = KC_RELEASE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] key_i,
   input  mag_t       mag_i,
   input  logic       tick,
   input  logic       tx_ready,
   output logic       busy,
   output logic       tx_req,
   output logic [7:0] tx_byte
);
   localparam int END_STD = SLOTS_PER * SLOT_TICKS;
   localparam int END_MAX = END_STD + 2 * GAP_TICKS;
   localparam int PT_W    = $clog2(END_MAX + 1);
   localparam int IX_W    = $clog2(SLOTS_PER + 3);

   logic            run_q, pend_q;
   logic [PT_W-1:0] ptick_q, evt_t, end_t;
   logic [IX_W-1:0] idx_q, n_ev;
   logic [7:0]      key_q, code;
   mag_t            mag_q;
   ev_kind_t        kind;
   logic            due, fin;

   always_comb begin
      n_ev = (mag_q == '0) ? '0 : IX_W'(mag_q) + IX_W'(2);
      if (idx_q < IX_W'(mag_q)) begin
         kind  = EV_MAKE;
         evt_t = PT_W'(int'(idx_q) * SLOT_TICKS);
      end else if (idx_q == IX_W'(mag_q)) begin
         kind  = EV_PREFIX;
         evt_t = PT_W'(int'(mag_q) * SLOT_TICKS);
      end else begin
         kind  = EV_BREAK;
         evt_t = PT_W'(int'(mag_q) * SLOT_TICKS + GAP_TICKS);
      end
      end_t = (mag_q == mag_t'(SLOTS_PER)) ? PT_W'(END_MAX) : PT_W'(END_STD);
      code  = (kind == EV_PREFIX) ? BRK_CODE : key_q;
      due   = run_q && !pend_q && (idx_q < n_ev) && (ptick_q == evt_t);
      fin   = run_q && !pend_q && (idx_q == n_ev) && (ptick_q == end_t);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         pend_q  <= 1'b0;
         ptick_q <= '0;
         idx_q   <= '0;
         key_q   <= '0;
         mag_q   <= '0;
         tx_req  <= 1'b0;
         tx_byte <= '0;
      end else begin
         tx_req <= 1'b0;
         if (start && !run_q) begin
            run_q   <= 1'b1;
            key_q   <= key_i;
            mag_q   <= mag_i;
            ptick_q <= '0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
         end else if (run_q) begin
            if (tick && ptick_q != end_t)
               ptick_q <= ptick_q + 1'b1;
            if (due) begin
               pend_q  <= 1'b1;
               tx_byte <= code;
               idx_q   <= idx_q + 1'b1;
            end else if (pend_q && tx_ready) begin
               tx_req <= 1'b1;
               pend_q <= 1'b0;
            end
            if (fin)
               run_q <= 1'b0;
         end
      end
   end

   assign busy = run_q;

   // R8
   req_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> $past(tx_ready));
   // R8
   req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> !tx_req);
   // R8
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> $stable(tx_byte));
   // R7
   latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |=> ($stable(key_q) && $stable(mag_q)));
   // R4
   zero_mag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && mag_q == '0) |-> (!tx_req && !pend_q));
endmodule

// File: rtl/axis_key_pwm.sv
module axis_key_pwm
   import akp_pkg::*;
#(
   parameter int         CLK_KHZ    = 125000,
   parameter int         TICK_US    = 500,
   parameter int         SLOT_TICKS = 32,
   parameter int         GAP_TICKS  = 4,
   parameter logic [7:0] POS_KEY    = KC_KP8,
   parameter logic [7:0] NEG_KEY    = KC_KP2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       smp_valid,
   input  logic [7:0] smp_data,
   output logic       smp_ready,
   input  logic       tx_ready,
   output logic       tx_req,
   output logic [7:0] tx_byte
);
   localparam int TICK_CYC = (CLK_KHZ * TICK_US) / 1000;

   generate
      if (GAP_TICKS < 1) begin : g_gap_bad
         $error("GAP_TICKS must be at least 1");
      end
      if (SLOT_TICKS < 2 * GAP_TICKS) begin : g_slot_bad
         $error("SLOT_TICKS must cover two byte gaps");
      end
   endgenerate

   logic       busy, accept, tick;
   logic [7:0] dec_key;
   mag_t       dec_mag;

   assign smp_ready = !busy;
   assign accept    = smp_valid && !busy;

   akp_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (accept),
      .tick  (tick)
   );

   akp_axis_decode #(
      .SMP_W    (8),
      .FOLD_NEG (1'b1),
      .POS_KEY  (POS_KEY),
      .NEG_KEY  (NEG_KEY)
   ) u_dec (
      .smp (smp_data),
      .key (dec_key),
      .mag (dec_mag)
   );

   akp_event_sched #(
      .SLOT_TICKS (SLOT_TICKS),
      .GAP_TICKS  (GAP_TICKS),
      .BRK_CODE   (KC_RELEASE)
   ) u_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .key_i    (dec_key),
      .mag_i    (dec_mag),
      .tick     (tick),
      .tx_ready (tx_ready),
      .busy     (busy),
      .tx_req   (tx_req),
      .tx_byte  (tx_byte)
   );

   // R7
   take_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_ready) |=> !smp_ready);
endmodule

// File: tb/axis_key_pwm_tb_top.sv
module axis_key_pwm_tb_top;
   localparam int TC = 4;
   localparam int SL = 8;
   localparam int GP = 2;

   logic       clk = 1'b0;
   logic       rst_n, smp_valid, tx_ready;
   logic [7:0] smp_data;
   logic       smp_ready, tx_req;
   logic [7:0] tx_byte;

   always #4 clk = ~clk;

   axis_key_pwm #(
      .CLK_KHZ (8), .TICK_US (500), .SLOT_TICKS (SL), .GAP_TICKS (GP),
      .POS_KEY (8'h75), .NEG_KEY (8'h72)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid), .smp_data (smp_data),
      .smp_ready (smp_ready), .tx_ready (tx_ready), .tx_req (tx_req), .tx_byte (tx_byte)
   );

   typedef struct {
      int         at;
      logic [7:0] b;
      string      tag;
   } ev_t;

   ev_t evq[$];
   int  cyc = 0;
   int  rdy_edge = 0;
   int  n_chk = 0;
   int  n_fail = 0;
   int  strobes = 0;
   bit  done = 0;
   logic rdy_last = 1'b1;

   function automatic int mag_of(logic [7:0] s);
      logic [7:0] f;
      f = s[7] ? s : ~s;
      return int'(f[6:4]);
   endfunction

   task automatic chk(string r, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   // behavioural schedule of one accepted sample (R2 R3 R5 R6 R7 R9)
   task automatic model_accept(int e0, logic [7:0] s);
      int m, endt;
      logic [7:0] k;
      ev_t e;
      m = mag_of(s);
      k = s[7] ? 8'h75 : 8'h72;
      for (int i = 0; i < m; i++) begin
         e.at = e0 + i * SL * TC + 2; e.b = k; e.tag = (i == 0) ? "R2 make" : "R5 make";
         evq.push_back(e);
      end
      if (m > 0) begin
         e.at = e0 + m * SL * TC + 2; e.b = 8'hF0; e.tag = "R6 prefix";
         evq.push_back(e);
         e.at = e0 + (m * SL + GP) * TC + 2; e.b = k; e.tag = "R6 release";
         evq.push_back(e);
      end
      endt = (m == 7) ? 7 * SL + 2 * GP : 7 * SL;
      rdy_edge = e0 + endt * TC + 1;
   endtask

   always @(posedge clk) begin
      if (rst_n === 1'b1 && smp_valid && cyc >= rdy_edge)
         model_accept(cyc + 1, smp_data);
      rdy_last = tx_ready;
      cyc = cyc + 1;
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         bit exp_req;
         exp_req = (evq.size() > 0) && (evq[0].at <= cyc) && rdy_last;
         n_chk++;
         if (tx_req !== exp_req) begin
            n_fail++;
            $display("FAIL %s (R9 timing) cycle %0d: actual req %0b expected %0b",
                     exp_req ? evq[0].tag : "R8", cyc, tx_req, exp_req);
         end
         if (exp_req) begin
            n_chk++;
            if (tx_byte !== evq[0].b) begin
               n_fail++;
               $display("FAIL %s byte cycle %0d: actual %02h expected %02h",
                        evq[0].tag, cyc, tx_byte, evq[0].b);
            end
            void'(evq.pop_front());
         end
         n_chk++;
         if (smp_ready !== (cyc >= rdy_edge)) begin
            n_fail++;
            $display("FAIL R7 ready cycle %0d: actual %0b expected %0b",
                     cyc, smp_ready, (cyc >= rdy_edge));
         end
         if (tx_req === 1'b1) strobes++;
      end
   end

   task automatic run_sample(logic [7:0] s, bit stall, bit glitch);
      int m;
      m = mag_of(s);
      strobes = 0;
      @(posedge clk); #1;
      smp_valid = 1'b1; smp_data = s;
      @(posedge clk); #1;
      smp_valid = 1'b0;
      if (glitch) begin
         // R7: valid while busy must be ignored
         repeat (10) @(posedge clk); #1;
         smp_valid = 1'b1; smp_data = 8'hAA;
         repeat (3) @(posedge clk); #1;
         smp_valid = 1'b0;
      end
      if (stall) begin
         // R8: ready low across the second make
         repeat (SL * TC - 1) @(posedge clk); #1;
         tx_ready = 1'b0;
         repeat (4) @(posedge clk); #1;
         tx_ready = 1'b1;
      end
      do @(negedge clk); while (smp_ready !== 1'b1);
      if (m == 0) chk("R4 bytes in zero period", strobes, 0);
      else        chk("R3 bytes in period", strobes, m + 2);
   endtask

   initial begin
      rst_n = 1'b0; smp_valid = 1'b0; smp_data = 8'h00; tx_ready = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 ready in reset", int'(smp_ready), 1);
      chk("R1 req in reset", int'(tx_req), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after reset", int'(smp_ready), 1);
      chk("R1 req after reset", int'(tx_req), 0);
      run_sample(8'hD0, 0, 0);
      run_sample(8'h35, 1, 0);
      run_sample(8'h80, 0, 0);
      run_sample(8'h00, 0, 1);
      run_sample(8'hFF, 0, 0);
      run_sample(8'h7F, 0, 0);
      run_sample(8'h9F, 0, 0);
      run_sample(8'h60, 0, 1);
      repeat (20) @(negedge clk);
      chk("R5 queue drained", evq.size(), 0);
      finish_up();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R7 watchdog: actual hung expected completion");
         finish_up();
      end
   end
endmodule